// File: doc/BRIEF.md
# Keyed Countdown Watchdog with Early Warning

This block is a system watchdog. A 32-bit counter runs down once per pulse of a slow tick enable, which is 32768 pulses per second, so the live count divided by 32768 gives the seconds left before expiry. Software sets a timeout value and an early-warning threshold. When the count passes the threshold, an early-warning flag is raised and can drive an interrupt. When the count reaches zero, an expiry flag is raised and a one-cycle reset request can be issued.

Software reaches the block through a flat register port: an address, a write strobe, write data and combinational read data. Every 32-bit value is split into a high half register and a low half register of 16 bits each. A key register guards the control, load and clear registers. Writes to those registers are dropped unless the key has been written first.

Writing the low half of the timeout or of the threshold commits both staged values. The commit also acts as the keep-alive kick. The new values reach the counter only after a fixed number of slow ticks, and a busy flag is shown until then.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block is in this state:
  - the key register (0x20) reads 1;
  - control (0x08), raw status (0x10), count low (0x18) and count high (0x1C) all read 0;
  - `irq` and `rst_req` are low.
- R2: The key register at 0x20 works as follows:
  - writing 0xE551 to bits 15:0 unlocks the block;
  - writing any other value locks it;
  - a read returns 1 when locked and 0 when unlocked.
- R3: While the block is locked, writes to these registers are ignored:
  - control (0x08);
  - timeout halves (high 0x04, low 0x00);
  - threshold halves (high 0x2C, low 0x30);
  - clear (0x0C).
- R4: Each 32-bit value is held as two halves:
  - the high register holds bits 31:16 and the low register holds bits 15:0;
  - the count halves at 0x1C and 0x18 show the live counter at all times.
- R5: Control bits are: 0 interrupt enable, 1 count enable, 2 mode flag (stored only), 3 reset enable. All four read back at 0x08.
- R6: A commit works as follows:
  - an unlocked write to 0x00 or to 0x30 commits the staged values;
  - raw status bit 4 (busy) is high from the next cycle;
  - on the LOAD_TICKS-th tick after the commit (default 2), the count takes the timeout value and busy falls;
  - a repeated commit is a keep-alive kick.
- R7: While control bit 1 is set, each tick lowers a nonzero count by one. The count holds at zero. The count does not change while bit 1 is clear.
- R8: When a decrement makes the count equal to the threshold, raw status bit 0 is set.
- R9: When a decrement makes the count zero:
  - raw status bit 3 is set;
  - `rst_req` pulses for exactly one cycle, but only if control bit 3 is set.
- R10: `irq` is high exactly when all three hold:
  - raw status bit 0 is set;
  - control bit 0 is set;
  - mask register (0x14) bit 0 is clear.
  
  The mask register can be written whether the block is locked or not.
- R11: An unlocked write to clear (0x0C) with bit 0 set clears raw bit 0. With bit 3 set, it clears raw bit 3.
- R12: Addresses that are not listed read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow tick enable, one cycle per counter step |
| addr | input | ADDR_W | Register byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The counter is first run through a threshold crossing and an expiry with every enable set. The interrupt is toggled with the mask, which shows that the mask gates only the output and not the raw flag. A second expiry runs with reset enable and interrupt enable both clear; it shows that the raw flags still set while `rst_req` and `irq` stay silent. A pause of count enable between kicks, and the busy flag read after one tick and then after two, separate a stalled counter from a load that lands one tick early or one tick late. Locked writes to control, to the load halves and to clear, each followed by a read-back, show that the key guards each path separately.

// File: rtl/wdog_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes byte addresses of at least 6 bits; offsets are the software map.
package wdog_pkg;
    localparam logic [7:0] OFF_TMO_LO  = 8'h00;
    localparam logic [7:0] OFF_TMO_HI  = 8'h04;
    localparam logic [7:0] OFF_CTRL    = 8'h08;
    localparam logic [7:0] OFF_CLEAR   = 8'h0C;
    localparam logic [7:0] OFF_RAW     = 8'h10;
    localparam logic [7:0] OFF_MASK    = 8'h14;
    localparam logic [7:0] OFF_CNT_LO  = 8'h18;
    localparam logic [7:0] OFF_CNT_HI  = 8'h1C;
    localparam logic [7:0] OFF_KEY     = 8'h20;
    localparam logic [7:0] OFF_WARN_HI = 8'h2C;
    localparam logic [7:0] OFF_WARN_LO = 8'h30;

    localparam logic [15:0] UNLOCK_KEY = 16'hE551;

    // Control register, bit 3 down to bit 0.
    typedef struct packed {
        logic rst_en;
        logic mode;
        logic cnt_en;
        logic int_en;
    } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
// Register file, key lock, clear strobes, commit strobe and read mux.
// Assumes DATA_W is even; each value is split into DATA_W/2-bit halves.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count,
    input  logic              raw_int,
    input  logic              raw_rst,
    input  logic              busy,
    output logic              locked,
    output wdog_ctrl_t        ctrl,
    output logic              mask_int,
    output logic [DATA_W-1:0] tmo_val,
    output logic [DATA_W-1:0] warn_val,
    output logic              commit,
    output logic              clr_int,
    output logic              clr_rst,
    output logic [DATA_W-1:0] rdata
);
    logic [HALF_W-1:0] tmo_hi, tmo_lo, warn_hi, warn_lo;
    logic              wr_open;
    logic              unused_wbits;

    assign wr_open      = wr_en && !locked;
    assign unused_wbits = ^wdata[DATA_W-1:HALF_W];
    assign tmo_val      = {tmo_hi, tmo_lo};
    assign warn_val     = {warn_hi, warn_lo};
    assign commit       = wr_open && (addr == ADDR_W'(OFF_TMO_LO) || addr == ADDR_W'(OFF_WARN_LO));
    assign clr_int      = wr_open && addr == ADDR_W'(OFF_CLEAR) && wdata[0];
    assign clr_rst      = wr_open && addr == ADDR_W'(OFF_CLEAR) && wdata[3];

    // Key lock: the key value opens, any other value closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b1;
        else if (wr_en && addr == ADDR_W'(OFF_KEY))
            locked <= (wdata[HALF_W-1:0] != UNLOCK_KEY[HALF_W-1:0]);
    end

    // Guarded control and staging registers; mask is unguarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            mask_int <= 1'b0;
            tmo_hi   <= '0;
            tmo_lo   <= '0;
            warn_hi  <= '0;
            warn_lo  <= '0;
        end else begin
            if (wr_en && addr == ADDR_W'(OFF_MASK)) mask_int <= wdata[0];
            if (wr_open) begin
                case (addr)
                    ADDR_W'(OFF_CTRL):    ctrl    <= wdog_ctrl_t'(wdata[3:0]);
                    ADDR_W'(OFF_TMO_HI):  tmo_hi  <= wdata[HALF_W-1:0];
                    ADDR_W'(OFF_TMO_LO):  tmo_lo  <= wdata[HALF_W-1:0];
                    ADDR_W'(OFF_WARN_HI): warn_hi <= wdata[HALF_W-1:0];
                    ADDR_W'(OFF_WARN_LO): warn_lo <= wdata[HALF_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Read mux: halves are zero-extended, unlisted addresses give zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_TMO_LO):  rdata[HALF_W-1:0] = tmo_lo;
            ADDR_W'(OFF_TMO_HI):  rdata[HALF_W-1:0] = tmo_hi;
            ADDR_W'(OFF_CTRL):    rdata[3:0]        = ctrl;
            ADDR_W'(OFF_RAW):     rdata[4:0]        = {busy, raw_rst, 2'b00, raw_int};
            ADDR_W'(OFF_MASK):    rdata[0]          = mask_int;
            ADDR_W'(OFF_CNT_LO):  rdata[HALF_W-1:0] = count[HALF_W-1:0];
            ADDR_W'(OFF_CNT_HI):  rdata[HALF_W-1:0] = count[DATA_W-1:HALF_W];
            ADDR_W'(OFF_KEY):     rdata[0]          = locked;
            ADDR_W'(OFF_WARN_HI): rdata[HALF_W-1:0] = warn_hi;
            ADDR_W'(OFF_WARN_LO): rdata[HALF_W-1:0] = warn_lo;
            default: ;
        endcase
    end
endmodule

// File: rtl/wdog_loader.sv
// Load handshake: holds busy after a commit and fires apply on the
// LOAD_TICKS-th slow tick. A new commit restarts the wait.
// Assumes LOAD_TICKS >= 1.
module wdog_loader #(
    parameter int LOAD_TICKS = 2,
    localparam int CW = $clog2(LOAD_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic commit,
    output logic busy,
    output logic apply
);
    logic [CW-1:0] seen;

    assign apply = busy && tick && !commit && (seen == CW'(LOAD_TICKS - 1));

    // Busy flag and tick count since the last commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            seen <= '0;
        end else if (commit) begin
            busy <= 1'b1;
            seen <= '0;
        end else if (apply) begin
            busy <= 1'b0;
            seen <= '0;
        end else if (busy && tick) begin
            seen <= seen + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
// Down-counter with threshold and expiry flags and the reset pulse.
// Assumes apply and tick arrive as single-cycle enables.
module wdog_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_en,
    input  logic              rst_en,
    input  logic              apply,
    input  logic [DATA_W-1:0] tmo_val,
    input  logic [DATA_W-1:0] warn_val,
    input  logic              clr_int,
    input  logic              clr_rst,
    output logic [DATA_W-1:0] count,
    output logic              raw_int,
    output logic              raw_rst,
    output logic              rst_req
);
    logic [DATA_W-1:0] warn_q;
    logic [DATA_W-1:0] next_cnt;
    logic              step, hit_warn, hit_zero;

    assign step     = tick && cnt_en && !apply && (count != '0);
    assign next_cnt = count - 1'b1;
    assign hit_warn = step && (next_cnt == warn_q);
    assign hit_zero = step && (next_cnt == '0);

    // Count register: load on apply, step down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            warn_q <= '0;
        end else if (apply) begin
            count  <= tmo_val;
            warn_q <= warn_val;
        end else if (step) begin
            count  <= next_cnt;
        end
    end

    // Sticky flags (a set wins over a clear) and the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_int <= 1'b0;
            raw_rst <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            raw_int <= hit_warn || (raw_int && !clr_int);
            raw_rst <= hit_zero || (raw_rst && !clr_rst);
            rst_req <= hit_zero && rst_en;
        end
    end
endmodule

// File: rtl/keyed_watchdog.sv
// Top level: joins the register file, the load handshake and the counter,
// and forms the masked interrupt.
// Assumes tick is a single-cycle enable in the clk domain.
module keyed_watchdog
    import wdog_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 6,
    parameter int LOAD_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);
    wdog_ctrl_t        ctrl;
    logic              locked, mask_int, commit, clr_int, clr_rst;
    logic              busy, apply, raw_int, raw_rst;
    logic [DATA_W-1:0] tmo_val, warn_val, count;

    wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .count(count), .raw_int(raw_int), .raw_rst(raw_rst), .busy(busy),
        .locked(locked), .ctrl(ctrl), .mask_int(mask_int),
        .tmo_val(tmo_val), .warn_val(warn_val), .commit(commit),
        .clr_int(clr_int), .clr_rst(clr_rst), .rdata(rdata)
    );

    wdog_loader #(.LOAD_TICKS(LOAD_TICKS)) u_load (
        .clk(clk), .rst_n(rst_n), .tick(tick), .commit(commit),
        .busy(busy), .apply(apply)
    );

    wdog_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_en(ctrl.cnt_en),
        .rst_en(ctrl.rst_en), .apply(apply), .tmo_val(tmo_val),
        .warn_val(warn_val), .clr_int(clr_int), .clr_rst(clr_rst),
        .count(count), .raw_int(raw_int), .raw_rst(raw_rst), .rst_req(rst_req)
    );

    assign irq = raw_int && ctrl.int_en && !mask_int;
endmodule

// File: rtl/wdog_chk.sv
// Checker for keyed_watchdog, attached by bind below.
// Assumes it is bound at the top with the internal nets named here.
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              locked,
    input logic [3:0]        ctrl,
    input logic              commit,
    input logic              busy,
    input logic [DATA_W-1:0] count,
    input logic              raw_int,
    input logic              rst_req,
    input logic              irq
);
    AST_LOCKED_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && addr == ADDR_W'(OFF_CTRL)) |=> $stable(ctrl)); // R3
    AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy); // R6
    AST_BUSY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !commit) |=> busy); // R6
    AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R7
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R9
    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw_int); // R10
endmodule

bind keyed_watchdog wdog_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .locked(locked), .ctrl(ctrl), .commit(commit), .busy(busy),
    .count(count), .raw_int(raw_int), .rst_req(rst_req), .irq(irq)
);

// File: tb/sim_keyed_watchdog.sv
// Directed bench for keyed_watchdog: one task per scenario.
module sim_keyed_watchdog;
    localparam int AW = 6;
    localparam logic [5:0] A_TLO = 6'h00, A_THI = 6'h04, A_CTL = 6'h08, A_CLR = 6'h0C,
                           A_RAW = 6'h10, A_MSK = 6'h14, A_CLO = 6'h18, A_CHI = 6'h1C,
                           A_KEY = 6'h20, A_WHI = 6'h2C, A_WLO = 6'h30;

    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rst_req;
    int checks = 0, errors = 0, pulses = 0;
    bit done = 1'b0;

    keyed_watchdog u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
                       .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n && rst_req) pulses++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; #1 v = rdata;
    endtask

    task automatic tk(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic cnt_is(string req, logic [31:0] exp);
        logic [31:0] lo, hi;
        rd(A_CLO, lo); rd(A_CHI, hi);
        chk(req, {hi[15:0], lo[15:0]}, exp);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_KEY, v); chk("R1 key", v, 1);
        rd(A_CTL, v); chk("R1 ctrl", v, 0);
        rd(A_RAW, v); chk("R1 raw", v, 0);
        cnt_is("R1 count", 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rst_req", {31'b0, rst_req}, 0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(A_KEY, 32'hE551); rd(A_KEY, v); chk("R2 unlocked", v, 0);
        wr(A_CTL, 32'hF); rd(A_CTL, v); chk("R5 ctrl readback", v, 32'hF);
        wr(A_KEY, 32'h0); rd(A_KEY, v); chk("R2 relocked", v, 1);
        wr(A_CTL, 32'h0); rd(A_CTL, v); chk("R3 ctrl held", v, 32'hF);
        wr(A_THI, 32'h7); rd(A_THI, v); chk("R3 load hi held", v, 0);
        wr(A_TLO, 32'h7); rd(A_RAW, v); chk("R3 no commit", v, 0);
        wr(A_KEY, 32'h1234); rd(A_KEY, v); chk("R2 wrong key", v, 1);
        wr(A_KEY, 32'hE551); wr(A_CTL, 32'h4); rd(A_CTL, v); chk("R5 mode bit", v, 32'h4);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_load();
        logic [31:0] v;
        wr(A_THI, 32'h0001); wr(A_TLO, 32'h0005);
        rd(A_RAW, v); chk("R6 busy set", v, 32'h10);
        tk(1); rd(A_RAW, v); chk("R6 busy after one tick", v, 32'h10);
        cnt_is("R6 not yet loaded", 0);
        tk(1); rd(A_RAW, v); chk("R6 busy cleared", v, 0);
        cnt_is("R4 split value", 32'h0001_0005);
    endtask

    task automatic t_run();
        logic [31:0] v;
        wr(A_THI, 0); wr(A_TLO, 5); wr(A_WHI, 0); wr(A_WLO, 3);
        tk(2); cnt_is("R6 reload", 5);
        wr(A_CTL, 32'hB);
        tk(1); cnt_is("R7 step", 4);
        rd(A_RAW, v); chk("R8 not yet", v, 0);
        tk(1); rd(A_RAW, v); chk("R8 threshold", v, 1);
        chk("R10 irq on", {31'b0, irq}, 1);
        wr(A_MSK, 1); #1 chk("R10 masked", {31'b0, irq}, 0);
        wr(A_MSK, 0); #1 chk("R10 unmasked", {31'b0, irq}, 1);
        tk(2); cnt_is("R7 count 1", 1);
        chk("R9 no pulse yet", pulses, 0);
        tk(1); rd(A_RAW, v); chk("R9 expiry flag", v, 32'h9);
        chk("R9 one pulse", pulses, 1);
        tk(1); cnt_is("R7 hold at zero", 0);
        chk("R9 still one pulse", pulses, 1);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(A_KEY, 0); wr(A_CLR, 32'h9);
        rd(A_RAW, v); chk("R3 clear held", v, 32'h9);
        wr(A_KEY, 32'hE551);
        wr(A_CLR, 32'h1); rd(A_RAW, v); chk("R11 clear bit0", v, 32'h8);
        chk("R10 irq off", {31'b0, irq}, 0);
        wr(A_CLR, 32'h8); rd(A_RAW, v); chk("R11 clear bit3", v, 0);
    endtask

    task automatic t_kick();
        logic [31:0] v;
        wr(A_TLO, 5); tk(2); cnt_is("R6 kick", 5);
        tk(1); cnt_is("R7 step after kick", 4);
        wr(A_CTL, 32'h9); tk(3); cnt_is("R7 paused", 4);
        wr(A_CTL, 32'h2); tk(4); cnt_is("R7 ran out", 0);
        rd(A_RAW, v); chk("R9 flags without reset enable", v, 32'h9);
        chk("R9 no pulse when disabled", pulses, 1);
        chk("R10 int enable off", {31'b0, irq}, 0);
    endtask

    task automatic t_holes();
        logic [31:0] v;
        rd(6'h24, v); chk("R12 hole 0x24", v, 0);
        rd(6'h28, v); chk("R12 hole 0x28", v, 0);
        rd(6'h3C, v); chk("R12 hole 0x3C", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_load();
        t_run();
        t_clear();
        t_kick();
        t_holes();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog timeout actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule